// File: doc/BRIEF.md
# DMA Channel Request Arbiter with Bus Attribute Encoder

This block sits in front of a four-channel DMA engine. It collects the channels' requests and grants the system bus to one channel at a time. Two channels are requested by active-low pins from off-chip peripherals, which are first synchronized. The other two are requested by level-sensitive interrupt lines from on-chip serial ports. Each channel has four configuration bits: enable, continuous mode, acknowledge-on-last-only, and single-address mode. The datapath reports each transfer boundary with `xfer_done` and flags the final transfer with `xfer_last`.

The grant can only move at a transfer boundary. Among the enabled requesters, the one with the lowest channel number wins. A channel in cycle-steal mode gives up the grant after every transfer. A channel in continuous mode keeps the grant until its final transfer completes. While a channel holds the bus, the block drives the bus transfer-type pins to mark a DMA access. It also drives a channel-acknowledge code and a single-address flag on the modifier pins.

All pins are plain control signals with no data stream, so there is no valid/ready handshake and no back-pressure. The attribute outputs follow the grant register and the live `xfer_last` input without added delay.

Top module: `dma_req_arbiter`

## Requirements
- R1: An external request pin driven low before clock edge k becomes visible to arbitration after two synchronizer stages. A grant from an idle state therefore appears after edge k+2.
- R2: An external request pin held high never produces a request or a grant for its channel.
- R3: When no channel holds the grant, the block grants the enabled requesting channel with the lowest index on the next edge. Channel 0 has the highest priority.
- R4: While a grant is held and `xfer_done` is low, `grant_valid` and `grant_ch` do not change.
- R5: A cycle-steal channel (its `ch_continuous` bit is 0) is re-arbitrated at every `xfer_done`. On the next edge the grant goes to the lowest-index enabled requester, which may be the same channel. If nothing requests, the grant is dropped.
- R6: A continuous channel keeps the grant across `xfer_done` while `xfer_last` is low. It is re-arbitrated as in R5 when `xfer_done` and `xfer_last` are high together.
- R7: `bus_ttype` is 2'b01 while a grant is held. With no grant, `bus_ttype` and `bus_tmod_ack` are 2'b00 and `bus_tmod_single` is 0.
- R8: `bus_tmod_ack` uses these codes: 2'b01 for channel 0, 2'b10 for channel 1, and 2'b00 for channels 2 and 3 and for no information. The code 2'b11 is never driven.
- R9: If the granted channel's `ch_ack_last_only` bit is set, its acknowledge code appears only while `xfer_last` is high, and 2'b00 is driven otherwise. If the bit is clear, the code appears on every cycle of the grant.
- R10: `bus_tmod_single` equals the granted channel's `ch_single_addr` bit and does not depend on `bus_tmod_ack`.
- R11: A channel whose `ch_enable` bit is 0 is never newly granted, even while it requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req_n | input | 2 | Active-low external requests for channels 0 and 1 |
| int_req | input | 2 | Active-high internal requests for channels 2 and 3 |
| ch_enable | input | 4 | Per-channel enable |
| ch_continuous | input | 4 | Per-channel continuous mode (0 = cycle-steal) |
| ch_ack_last_only | input | 4 | Per-channel acknowledge on final transfer only |
| ch_single_addr | input | 4 | Per-channel single-address mode |
| xfer_done | input | 1 | Transfer boundary pulse from the datapath |
| xfer_last | input | 1 | Current transfer is the final one |
| grant_valid | output | 1 | A channel holds the bus |
| grant_ch | output | 2 | Index of the granted channel |
| bus_ttype | output | 2 | Transfer type attribute |
| bus_tmod_ack | output | 2 | Channel-acknowledge modifier field |
| bus_tmod_single | output | 1 | Single-address modifier bit |

## Verification
The bench builds the block with its defaults: four channels, two of them external, and a two-stage synchronizer. With these values both request paths are exercised, both acknowledge codes can be driven, and two channels must map to the empty code 2'b00. The fixed synchronizer depth lets a directed test pin the grant latency to an exact cycle. A small channel count means short random runs still hit every mix of priority collisions, continuous holds and last-transfer releases many times.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam logic [1:0] TT_IDLE  = 2'b00;
  localparam logic [1:0] TT_DMA   = 2'b01;
  localparam logic [1:0] ACK_NONE = 2'b00;
  localparam logic [1:0] ACK_RSVD = 2'b11;

  // acknowledge code for an externally requested channel index
  function automatic logic [1:0] ack_code(input int unsigned idx);
    return 2'(idx + 1);
  endfunction
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int NUM = 2,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] req_n_in,
  output logic [NUM-1:0] req_out
);
  for (genvar i = 0; i < NUM; i++) begin : g_bit
    logic [STAGES-1:0] shreg;
    always_ff @(posedge clk) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], ~req_n_in[i]};
    end
    assign req_out[i] = shreg[STAGES-1];
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_vec,
  input  logic [N-1:0] cont_mask,
  input  logic         xfer_done,
  input  logic         xfer_last,
  output logic         gnt_valid,
  output logic [W-1:0] gnt_ch
);
  logic         pick_any;
  logic [W-1:0] pick_idx;
  logic         boundary, hold_cont, rearb;

  dma_prio_pick #(.N(N)) u_pick (
    .req (req_vec),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign boundary  = gnt_valid && xfer_done;
  assign hold_cont = boundary && cont_mask[gnt_ch] && !xfer_last;
  assign rearb     = !gnt_valid || (boundary && !hold_cont);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_ch    <= '0;
    end else if (rearb) begin
      gnt_valid <= pick_any;
      if (pick_any) gnt_ch <= pick_idx;
    end
  end

  assert_hold_midxfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_ch)));

  assert_ch0_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && req_vec[0]) |=> (gnt_valid && gnt_ch == '0));

  assert_idle_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && |req_vec) |=> gnt_valid);

  assert_cont_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done && cont_mask[gnt_ch] && !xfer_last)
      |=> (gnt_valid && $stable(gnt_ch)));

  assert_steal_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done && !cont_mask[gnt_ch] && req_vec == '0) |=> !gnt_valid);
endmodule

// File: rtl/dma_attr_enc.sv
module dma_attr_enc
  import dma_arb_pkg::*;
#(
  parameter int N = 4,
  parameter int NUM_EXT = 2,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gnt_valid,
  input  logic [W-1:0] gnt_ch,
  input  logic [N-1:0] ack_last_mask,
  input  logic [N-1:0] single_mask,
  input  logic         xfer_last,
  output logic [1:0]   ttype,
  output logic [1:0]   tmod_ack,
  output logic         tmod_single
);
  logic ack_window;

  assign ack_window = !ack_last_mask[gnt_ch] || xfer_last;

  always_comb begin
    ttype       = TT_IDLE;
    tmod_ack    = ACK_NONE;
    tmod_single = 1'b0;
    if (gnt_valid) begin
      ttype       = TT_DMA;
      tmod_single = single_mask[gnt_ch];
      if (ack_window && int'(gnt_ch) < NUM_EXT)
        tmod_ack = ack_code(int'(gnt_ch));
    end
  end

  assert_ack_not_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmod_ack != ACK_RSVD);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (ttype == TT_IDLE && tmod_ack == ACK_NONE && !tmod_single));

  assert_last_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && ack_last_mask[gnt_ch] && !xfer_last) |-> tmod_ack == ACK_NONE);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH = 4,
  parameter int NUM_EXT = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_INT = NUM_CH - NUM_EXT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_req_n,
  input  logic [NUM_INT-1:0] int_req,
  input  logic [NUM_CH-1:0]  ch_enable,
  input  logic [NUM_CH-1:0]  ch_continuous,
  input  logic [NUM_CH-1:0]  ch_ack_last_only,
  input  logic [NUM_CH-1:0]  ch_single_addr,
  input  logic               xfer_done,
  input  logic               xfer_last,
  output logic               grant_valid,
  output logic [CH_W-1:0]    grant_ch,
  output logic [1:0]         bus_ttype,
  output logic [1:0]         bus_tmod_ack,
  output logic               bus_tmod_single
);
  logic [NUM_EXT-1:0] ext_req_sync;
  logic [NUM_CH-1:0]  req_vec;

  dma_req_sync #(.NUM(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n_in (ext_req_n),
    .req_out  (ext_req_sync)
  );

  assign req_vec = {int_req, ext_req_sync} & ch_enable;

  dma_grant_ctrl #(.N(NUM_CH)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vec   (req_vec),
    .cont_mask (ch_continuous),
    .xfer_done (xfer_done),
    .xfer_last (xfer_last),
    .gnt_valid (grant_valid),
    .gnt_ch    (grant_ch)
  );

  dma_attr_enc #(.N(NUM_CH), .NUM_EXT(NUM_EXT)) u_attr (
    .clk           (clk),
    .rst_n         (rst_n),
    .gnt_valid     (grant_valid),
    .gnt_ch        (grant_ch),
    .ack_last_mask (ch_ack_last_only),
    .single_mask   (ch_single_addr),
    .xfer_last     (xfer_last),
    .ttype         (bus_ttype),
    .tmod_ack      (bus_tmod_ack),
    .tmod_single   (bus_tmod_single)
  );

  assert_disabled_never_new_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && req_vec == '0) |=> !grant_valid);

  assert_single_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (bus_tmod_single == ch_single_addr[grant_ch]));
endmodule

// File: tb/dma_req_arbiter_tb_top.sv
module dma_req_arbiter_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [1:0] ext_req_n, int_req;
  logic [3:0] ch_enable, ch_continuous, ch_ack_last_only, ch_single_addr;
  logic       xfer_done, xfer_last;
  logic       grant_valid, bus_tmod_single;
  logic [1:0] grant_ch, bus_ttype, bus_tmod_ack;

  dma_req_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .int_req(int_req),
    .ch_enable(ch_enable), .ch_continuous(ch_continuous),
    .ch_ack_last_only(ch_ack_last_only), .ch_single_addr(ch_single_addr),
    .xfer_done(xfer_done), .xfer_last(xfer_last),
    .grant_valid(grant_valid), .grant_ch(grant_ch), .bus_ttype(bus_ttype),
    .bus_tmod_ack(bus_tmod_ack), .bus_tmod_single(bus_tmod_single)
  );

  int n_run = 0, n_fail = 0;
  string tag = "R7";
  bit comparing = 0;
  bit finished = 0;

  // behavioural reference: a queue per external pin models the synchronizer
  bit q_ext0[$], q_ext1[$];
  bit m_gv;
  int m_gch;

  function automatic int lowest(input bit [3:0] r);
    for (int i = 0; i < 4; i++) if (r[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_ext0 = '{0, 0}; q_ext1 = '{0, 0};
      m_gv = 0; m_gch = 0;
    end else begin
      bit [3:0] r;
      int w;
      r = {int_req[1], int_req[0], q_ext1[0], q_ext0[0]} & ch_enable;
      w = lowest(r);
      if (!m_gv || (xfer_done && !(ch_continuous[m_gch] && !xfer_last))) begin
        m_gv = (w >= 0);
        if (w >= 0) m_gch = w;
      end
      void'(q_ext0.pop_front()); void'(q_ext1.pop_front());
      q_ext0.push_back(!ext_req_n[0]); q_ext1.push_back(!ext_req_n[1]);
    end
  end

  task automatic chk(string t, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && rst_n) begin
      int e_ack;
      e_ack = 0;
      if (m_gv && m_gch < 2 && (!ch_ack_last_only[m_gch] || xfer_last)) e_ack = m_gch + 1;
      chk({tag, " grant_valid"}, grant_valid, m_gv);
      if (m_gv) chk({tag, " grant_ch"}, grant_ch, m_gch);
      chk("R7 bus_ttype", bus_ttype, m_gv ? 1 : 0);
      chk({tag, " R8 R9 bus_tmod_ack"}, bus_tmod_ack, e_ack);
      chk("R10 bus_tmod_single", bus_tmod_single, m_gv ? int'(ch_single_addr[m_gch]) : 0);
      if (bus_tmod_ack == 2'b11) chk("R8 reserved ack code", 3, 0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_rand(string t, int cycles, bit vary_ext, bit vary_int);
    tag = t;
    for (int c = 0; c < cycles; c++) begin
      if (vary_ext) ext_req_n = 2'($urandom_range(0, 3));
      if (vary_int) int_req = 2'($urandom_range(0, 3));
      xfer_done = ($urandom_range(0, 3) == 0);
      xfer_last = ($urandom_range(0, 4) == 0);
      step();
    end
    xfer_done = 0; xfer_last = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 0; ext_req_n = 2'b11; int_req = 0; ch_enable = 4'hF;
    ch_continuous = 0; ch_ack_last_only = 0; ch_single_addr = 0;
    xfer_done = 0; xfer_last = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset grant_valid", grant_valid, 0);
    chk("R7 reset bus_ttype", bus_ttype, 0);
    chk("R7 reset bus_tmod_ack", bus_tmod_ack, 0);
    step(); rst_n = 1; comparing = 1;

    // R2: pins high, internals idle, all enabled
    tag = "R2";
    repeat (8) step();
    @(negedge clk); chk("R2 no grant with pins high", grant_valid, 0);

    // R1: pin 1 low, latency through synchronizer
    step(); ext_req_n = 2'b01; tag = "R1";
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 not yet granted after two edges", grant_valid, 0);
    @(negedge clk);
    chk("R1 granted after third edge", grant_valid, 1);
    chk("R1 granted channel", grant_ch, 1);
    chk("R8 channel 1 ack code", bus_tmod_ack, 2);
    chk("R7 ttype while granted", bus_ttype, 1);

    // R4: held with no boundary while a higher-priority request appears
    step(); ext_req_n = 2'b00; tag = "R4";
    repeat (5) step();
    @(negedge clk); chk("R4 grant held mid transfer", grant_ch, 1);

    // R3: boundary re-evaluates in priority order
    step(); xfer_done = 1; tag = "R3"; step(); xfer_done = 0;
    @(negedge clk); chk("R3 channel 0 wins at boundary", grant_ch, 0);
    chk("R8 channel 0 ack code", bus_tmod_ack, 1);

    // R5: cycle-steal release when nothing requests
    step(); ext_req_n = 2'b11; repeat (3) step();
    xfer_done = 1; tag = "R5"; step(); xfer_done = 0;
    @(negedge clk); chk("R5 release with no requests", grant_valid, 0);

    // R8: internal channel ack is empty
    step(); int_req = 2'b10; tag = "R8"; step();
    @(negedge clk); chk("R8 channel 3 granted", grant_ch, 3);
    chk("R8 channel 3 ack empty", bus_tmod_ack, 0);
    step(); int_req = 0; xfer_done = 1; step(); xfer_done = 0;

    // R11: disabled channels never granted
    ch_enable = 4'b1010; ext_req_n = 2'b10; int_req = 2'b01; tag = "R11";
    repeat (6) step();
    @(negedge clk); chk("R11 disabled channels not granted", grant_valid, 0);
    run_rand("R11", 400, 1, 1);
    ch_enable = 4'hF;

    run_rand("R3", 600, 1, 1);
    ch_continuous = 4'hF;  run_rand("R6", 800, 1, 1);
    ch_continuous = 4'b0101; run_rand("R5", 800, 1, 1);
    ch_ack_last_only = 4'hF; run_rand("R9", 800, 1, 1);
    ch_ack_last_only = 4'b0010; ch_single_addr = 4'b1001; run_rand("R10", 800, 1, 1);
    ch_single_addr = 4'hF; run_rand("R10", 400, 0, 1);
    ext_req_n = 2'b11; run_rand("R2", 400, 0, 1);
    for (int k = 0; k < 8; k++) begin
      ch_enable = 4'($urandom_range(0, 15));
      ch_continuous = 4'($urandom_range(0, 15));
      ch_ack_last_only = 4'($urandom_range(0, 15));
      ch_single_addr = 4'($urandom_range(0, 15));
      run_rand("R4", 500, 1, 1);
    end
    comparing = 0;
    summary();
  end
endmodule